// File: doc/BRIEF.md
# Background Memory Scrubber

This block keeps long-lived data in an error-corrected memory from wearing down. Soft errors in stored words build up slowly. A word with one flipped bit can still be corrected, but a second flip in the same word can no longer be repaired. The scrubber visits every address of a configured window, one at a time and in ascending order. For each address it reads the word and looks at the ECC verdict returned with the data. When the verdict says a single error was corrected, it writes the corrected word back to the same address, so the stored copy is clean again.

The scrubber has the lowest priority on the memory. It asks for each access through a request/grant pair and keeps asking until an arbiter lets it in, so normal traffic always goes first. A programmable gap timer spaces out the accesses, and a full sweep of a large memory can take hours. Words that cannot be corrected are never written. Instead they are counted, and the address of the most recent one is kept. At the end of each sweep the walk returns to the first address, a pulse marks the finished pass, and a pass counter advances.

Top module: `scrub_engine`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `arb_req`, `cmd_valid` and `pass_done` are 0, and `pass_count`, `ue_count` and `ue_addr` are 0.
- R2: Each location is paced by the gap timer. When `cfg_enable` is first seen high while idle, or after an address has been finished with the scrubber still enabled, `arb_req` rises on the (`cfg_gap_cycles`+2)-th clock edge after that event.
- R3: Once raised, `arb_req` stays high until a cycle with `arb_gnt` high. A command (`cmd_valid`) is issued only in such a cycle, and only in that one cycle.
- R4: Within a pass, reads go to every address from `cfg_first_addr` up to `cfg_last_addr` in ascending order, each one exactly once.
- R5: `rsp_status` is coded as follows: 2'b00 means clean, 2'b01 means corrected, and 2'b10 or 2'b11 means uncorrectable. After a corrected response, the next command is a write (`cmd_write`=1) to the same address, and its `cmd_wdata` equals the `rsp_data` that came back.
- R6: A clean response causes no write. The walk moves on to the next address.
- R7: An uncorrectable response causes no write. `ue_count` goes up by one, and `ue_addr` takes the address that failed.
- R8: After `cfg_last_addr` has been handled, the next read goes to `cfg_first_addr`. `pass_done` is high for exactly one cycle, and `pass_count` goes up by one in that same cycle.
- R9: With `SATURATE`=1, `pass_count` and `ue_count` stop at all ones and do not wrap.
- R10: `cfg_enable` is sampled only while the scrubber is idle or waiting on the gap timer. A read, its response and any write-back that have already started still finish. Once the scrubber is idle it raises no request, and enabling it again starts the walk at `cfg_first_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Runs the walk |
| cfg_first_addr | input | ADDR_W | Lowest address of the window |
| cfg_last_addr | input | ADDR_W | Highest address of the window |
| cfg_gap_cycles | input | IVL_W | Idle cycles inserted before each location |
| arb_req | output | 1 | Request for one memory access |
| arb_gnt | input | 1 | Grant from the arbiter |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_write | output | 1 | 1 = write-back, 0 = read |
| cmd_addr | output | ADDR_W | Address of the command |
| cmd_wdata | output | DATA_W | Corrected data for a write-back |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | DATA_W | Data returned, already corrected by the decoder |
| rsp_status | input | 2 | ECC verdict for the returned data |
| pass_done | output | 1 | One-cycle pulse at the end of each sweep |
| pass_count | output | CNT_W | Number of sweeps completed |
| ue_count | output | CNT_W | Number of uncorrectable words found |
| ue_addr | output | ADDR_W | Address of the most recent uncorrectable word |

## Verification
The assertions rely on the arbiter and the memory behaving as an orderly system. The arbiter may drive a grant at any time, but a grant only has meaning while a request is pending. The memory returns exactly one response for each read, and only while the scrubber is waiting for it. The window satisfies `cfg_first_addr` ≤ `cfg_last_addr`, and it is changed only while the scrubber is idle. The bench keeps within these rules. Its memory model answers each read once, after a fixed latency. Its grant follows either a constant-high pattern or a pseudo-random pattern. It changes the window only after it has disabled the scrubber and its reference model shows the scrubber idle.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

   typedef enum logic [2:0] {
      SC_IDLE,
      SC_GAP,
      SC_RD_ASK,
      SC_RD_WAIT,
      SC_WB_ASK,
      SC_STEP
   } scrub_state_t;

   localparam logic [1:0] ECC_OK    = 2'b00;
   localparam logic [1:0] ECC_FIXED = 2'b01;

   function automatic logic ecc_is_fatal(input logic [1:0] status);
      return status[1];
   endfunction

endpackage

// File: rtl/scrub_gap_timer.sv
module scrub_gap_timer #(
   parameter int IVL_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IVL_W-1:0] load_val,
   input  logic             run,
   output logic             expired
);
   localparam logic [IVL_W-1:0] ONE = IVL_W'(1);

   logic [IVL_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain <= '0;
      else if (load)
         remain <= load_val;
      else if (run && (remain != '0))
         remain <= remain - ONE;
   end

   assign expired = (remain == '0);
endmodule

// File: rtl/scrub_addr_walker.sv
module scrub_addr_walker #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              advance,
   input  logic [ADDR_W-1:0] first_addr,
   input  logic [ADDR_W-1:0] last_addr,
   output logic [ADDR_W-1:0] addr,
   output logic              at_last
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (restart)
         addr <= first_addr;
      else if (advance)
         addr <= at_last ? first_addr : addr + ONE;
   end

   assign at_last = (addr == last_addr);
endmodule

// File: rtl/scrub_event_counter.sv
module scrub_event_counter #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic hold;

   generate
      if (SATURATE) begin : g_sat
         assign hold = &count;
      end else begin : g_wrap
         assign hold = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (bump && !hold)
         count <= count + ONE;
   end
endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
   import scrub_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 64,
   parameter int IVL_W    = 24,
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [ADDR_W-1:0] cfg_first_addr,
   input  logic [ADDR_W-1:0] cfg_last_addr,
   input  logic [IVL_W-1:0]  cfg_gap_cycles,
   output logic              arb_req,
   input  logic              arb_gnt,
   output logic              cmd_valid,
   output logic              cmd_write,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_wdata,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic [1:0]        rsp_status,
   output logic              pass_done,
   output logic [CNT_W-1:0]  pass_count,
   output logic [CNT_W-1:0]  ue_count,
   output logic [ADDR_W-1:0] ue_addr
);

   generate
      if (ADDR_W < 1 || ADDR_W > 48) begin : g_bad_aw
         $error("scrub_engine: ADDR_W must be 1..48");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("scrub_engine: DATA_W must be positive");
      end
      if (IVL_W < 1 || CNT_W < 1) begin : g_bad_cw
         $error("scrub_engine: IVL_W and CNT_W must be positive");
      end
   endgenerate

   scrub_state_t st, st_nx;

   logic              gap_load, gap_expired;
   logic              walk_restart, walk_advance, walk_last;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] fix_data;
   logic              resp_here, resp_fixed, resp_fatal;
   logic              pass_bump;

   assign resp_here  = (st == SC_RD_WAIT) && rsp_valid;
   assign resp_fatal = resp_here && ecc_is_fatal(rsp_status);
   assign resp_fixed = resp_here && (rsp_status == ECC_FIXED);

   always_comb begin
      st_nx = st;
      unique case (st)
         SC_IDLE:    if (cfg_enable) st_nx = SC_GAP;
         SC_GAP: begin
            if (!cfg_enable)      st_nx = SC_IDLE;
            else if (gap_expired) st_nx = SC_RD_ASK;
         end
         SC_RD_ASK:  if (arb_gnt) st_nx = SC_RD_WAIT;
         SC_RD_WAIT: begin
            if (resp_here) st_nx = resp_fixed ? SC_WB_ASK : SC_STEP;
         end
         SC_WB_ASK:  if (arb_gnt) st_nx = SC_STEP;
         SC_STEP:    st_nx = cfg_enable ? SC_GAP : SC_IDLE;
         default:    st_nx = SC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st <= SC_IDLE;
      else
         st <= st_nx;
   end

   assign gap_load     = (st_nx == SC_GAP) && (st != SC_GAP);
   assign walk_restart = (st == SC_IDLE) && cfg_enable;
   assign walk_advance = (st == SC_STEP);
   assign pass_bump    = walk_advance && walk_last;

   scrub_gap_timer #(.IVL_W(IVL_W)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (gap_load),
      .load_val (cfg_gap_cycles),
      .run      (st == SC_GAP),
      .expired  (gap_expired)
   );

   scrub_addr_walker #(.ADDR_W(ADDR_W)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (walk_restart),
      .advance    (walk_advance),
      .first_addr (cfg_first_addr),
      .last_addr  (cfg_last_addr),
      .addr       (cur_addr),
      .at_last    (walk_last)
   );

   scrub_event_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_pass_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (pass_bump),
      .count (pass_count)
   );

   scrub_event_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_ue_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (resp_fatal),
      .count (ue_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fix_data  <= '0;
         ue_addr   <= '0;
         pass_done <= 1'b0;
      end else begin
         pass_done <= pass_bump;
         if (resp_fixed) fix_data <= rsp_data;
         if (resp_fatal) ue_addr  <= cur_addr;
      end
   end

   assign arb_req   = (st == SC_RD_ASK) || (st == SC_WB_ASK);
   assign cmd_valid = arb_req && arb_gnt;
   assign cmd_write = (st == SC_WB_ASK);
   assign cmd_addr  = cur_addr;
   assign cmd_wdata = fix_data;

endmodule

// File: rtl/scrub_engine_chk.sv
module scrub_engine_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arb_req,
   input logic             arb_gnt,
   input logic             cmd_valid,
   input logic             cmd_write,
   input logic             pass_done,
   input logic [CNT_W-1:0] pass_count,
   input logic [CNT_W-1:0] ue_count
);
   // R3
   cmd_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (arb_req && arb_gnt));

   // R3
   req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_req && !arb_gnt) |=> arb_req);

   // R5
   wb_then_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_write) |=> !arb_req);

   // R3
   read_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_write) |=> !arb_req);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> !pass_done);

   // R8
   done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |-> !arb_req);

   // R7
   ue_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ue_count) |-> (ue_count == CNT_W'($past(ue_count) + 1'b1)));

   // R8
   pass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pass_count) |-> (pass_count == CNT_W'($past(pass_count) + 1'b1)));
endmodule

bind scrub_engine scrub_engine_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .arb_req    (arb_req),
   .arb_gnt    (arb_gnt),
   .cmd_valid  (cmd_valid),
   .cmd_write  (cmd_write),
   .pass_done  (pass_done),
   .pass_count (pass_count),
   .ue_count   (ue_count)
);

// File: tb/scrub_engine_test.sv
`timescale 1ns/1ps
module scrub_engine_test;
   localparam int AW = 6;
   localparam int DW = 32;
   localparam int IW = 8;
   localparam int CW = 4;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic [AW-1:0] first_a = '0, last_a = '0;
   logic [IW-1:0] gap = '0;
   logic          arb_req, arb_gnt = 1'b0;
   logic          cmd_valid, cmd_write;
   logic [AW-1:0] cmd_addr;
   logic [DW-1:0] cmd_wdata;
   logic          rsp_valid = 1'b0;
   logic [DW-1:0] rsp_data = '0;
   logic [1:0]    rsp_status = '0;
   logic          pass_done;
   logic [CW-1:0] pass_count, ue_count;
   logic [AW-1:0] ue_addr;

   scrub_engine #(.ADDR_W(AW), .DATA_W(DW), .IVL_W(IW), .CNT_W(CW), .SATURATE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_first_addr(first_a),
      .cfg_last_addr(last_a), .cfg_gap_cycles(gap), .arb_req(arb_req), .arb_gnt(arb_gnt),
      .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_status(rsp_status),
      .pass_done(pass_done), .pass_count(pass_count), .ue_count(ue_count), .ue_addr(ue_addr));

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // memory and arbiter model
   logic [1:0] errs [0:63];
   int  lat = 1;
   bit  rnd_gnt = 0;
   logic [7:0] lfsr = 8'hA5;
   bit  pend = 0;
   int  pend_addr = 0, pend_cnt = 0;
   int  wr_cnt = 0;
   bit  wr_bad = 0;

   function automatic logic [DW-1:0] good(int a);
      return DW'(a * 32'h9E3779B1) ^ 32'h0F1E2D3C;
   endfunction

   // reference model: 0 idle,1 gap,2 read ask,3 wait data,4 write ask,5 step
   int m_st = 0, m_tmr = 0, m_addr = 0, m_pc = 0, m_ue = 0, m_ueaddr = 0;
   bit m_done = 0;
   logic [DW-1:0] m_wd = '0;

   task automatic step();
      bit e_req, e_cv, e_cw;
      @(negedge clk);
      arb_gnt = rnd_gnt ? lfsr[0] : 1'b1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (pend && pend_cnt == 0) begin
         rsp_valid = 1'b1; rsp_status = errs[pend_addr]; rsp_data = good(pend_addr);
      end else begin
         rsp_valid = 1'b0; rsp_status = 2'b00; rsp_data = '0;
      end
      #1;
      e_req = rst_n && (m_st == 2 || m_st == 4);
      e_cv  = e_req && arb_gnt;
      e_cw  = (m_st == 4);
      chk("R2/R3", "arb_req", arb_req, e_req);
      chk("R3", "cmd_valid", cmd_valid, e_cv);
      if (e_cv) begin
         chk("R5", "cmd_write", cmd_write, e_cw);
         chk("R4", "cmd_addr", cmd_addr, m_addr);
         if (e_cw) chk("R5", "cmd_wdata", cmd_wdata, m_wd);
      end
      chk("R8", "pass_done", pass_done, m_done);
      chk("R8", "pass_count", pass_count, m_pc);
      chk("R7", "ue_count", ue_count, m_ue);
      chk("R7", "ue_addr", ue_addr, m_ueaddr);
      @(posedge clk);
      #1;
      if (!rst_n) begin
         m_st = 0; m_tmr = 0; m_addr = 0; m_pc = 0; m_ue = 0; m_ueaddr = 0; m_done = 0; m_wd = '0;
         pend = 0;
      end else begin
         if (pend) begin
            if (pend_cnt == 0) pend = 0; else pend_cnt--;
         end
         if (e_cv && !e_cw) begin
            pend = 1; pend_addr = m_addr; pend_cnt = lat;
         end
         if (e_cv && e_cw) begin
            wr_cnt++;
            if (errs[m_addr] != 2'b01) wr_bad = 1;
            errs[m_addr] = 2'b00;
         end
         m_done = 0;
         case (m_st)
            0: if (en) begin m_st = 1; m_tmr = gap; m_addr = first_a; end
            1: if (!en) m_st = 0; else if (m_tmr == 0) m_st = 2; else m_tmr--;
            2: if (arb_gnt) m_st = 3;
            3: if (rsp_valid) begin
                  if (rsp_status == 2'b00) m_st = 5;
                  else if (rsp_status == 2'b01) begin m_wd = rsp_data; m_st = 4; end
                  else begin
                     if (m_ue < CMAX) m_ue++;
                     m_ueaddr = m_addr; m_st = 5;
                  end
               end
            4: if (arb_gnt) m_st = 5;
            default: begin
               if (m_addr == last_a) begin
                  m_addr = first_a; m_done = 1;
                  if (m_pc < CMAX) m_pc++;
               end else m_addr++;
               if (en) begin m_st = 1; m_tmr = gap; end else m_st = 0;
            end
         endcase
      end
   endtask

   task automatic run_passes(int n);
      int target = m_pc + n;
      for (int g = 0; g < 4000 && m_pc < target; g++) step();
   endtask

   task automatic go_idle();
      en = 1'b0;
      for (int g = 0; g < 200 && m_st != 0; g++) step();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) errs[i] = 2'b00;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1", "reset arb_req", arb_req, 0);
      chk("R1", "reset pass_count", pass_count, 0);
      chk("R1", "reset ue_count", ue_count, 0);
      chk("R1", "reset ue_addr", ue_addr, 0);

      // clean sweep, immediate grant
      first_a = 6'd4; last_a = 6'd11; gap = 8'd3; lat = 1; en = 1'b1;
      run_passes(2);
      chk("R6", "writes on clean memory", wr_cnt, 0);
      chk("R8", "pass count after two sweeps", pass_count, 2);

      // errors with random grant and longer latency
      go_idle();
      errs[6] = 2'b01; errs[9] = 2'b10; errs[10] = 2'b11;
      rnd_gnt = 1; lat = 3; gap = 8'd1; en = 1'b1;
      run_passes(1);
      chk("R5", "one write-back in sweep", wr_cnt, 1);
      chk("R5", "corrected word repaired", errs[6], 2'b00);
      chk("R7", "no write to bad word", wr_bad, 0);
      chk("R7", "ue_count after sweep", ue_count, 2);
      chk("R7", "ue_addr last failing", ue_addr, 10);
      run_passes(1);
      chk("R5", "no write-back once repaired", wr_cnt, 1);
      chk("R7", "ue_count second sweep", ue_count, 4);

      // disable, stay quiet, then single-location window
      go_idle();
      for (int i = 0; i < 20; i++) begin
         step();
         chk("R10", "no request while idle", arb_req, 0);
      end
      first_a = 6'd20; last_a = 6'd20; gap = 8'd0; lat = 1; rnd_gnt = 0; en = 1'b1;
      run_passes(3);
      chk("R8", "single-location passes", pass_count, 7);

      // saturation
      go_idle();
      errs[30] = 2'b10; errs[31] = 2'b11;
      first_a = 6'd30; last_a = 6'd31; en = 1'b1;
      for (int i = 0; i < 400; i++) step();
      chk("R9", "pass_count saturates", pass_count, CMAX);
      chk("R9", "ue_count saturates", ue_count, CMAX);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule